// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a parameterised set of general-purpose input pins (four banks of 32 by default, 128 pins) and records edges on them as interrupt events. Software arms each pin separately for rising edges, falling edges, or both. The pin is then resynchronised into the core clock domain. When an armed edge is seen on a pin configured as an input, a sticky status bit is set for that pin. Software clears a status bit by writing a one to it.

The first two pins each have a dedicated interrupt output. Every other pin feeds one shared summary interrupt, so software reads the status banks to find which pins fired. All configuration and status sit behind one simple register port. Each bank has four registers, addressed by bank number and register select. Reads return the addressed register one cycle after the address is presented.

Top module: `gpio_edge_irq`

## Requirements
- R1: Each pin has its own rising-edge enable bit and falling-edge enable bit. With only the rising enable set, only 0-to-1 transitions are recorded. With only the falling enable set, only 1-to-0 transitions are recorded. With both set, either transition is recorded.
- R2: `reg_addr` is {bank, sel}. The bank number occupies the upper bits and `sel` the low two bits. The values of `sel` are 0 = rising enables, 1 = falling enables, 2 = edge status, 3 = direction. Pin p lives in bank p>>5 at bit p&31.
- R3: Status bits are sticky. A write to the status register clears exactly the bits written as 1 and leaves the others unchanged. Writing back a value just read clears exactly the bits that were set.
- R4: `irq_pin0` equals the status bit of pin 0, and `irq_pin1` equals the status bit of pin 1.
- R5: `irq_summary` is the OR of the status bits of pins 2 and above, and it updates in the same cycle as those bits.
- R6: A pin with both enable bits cleared records no edges.
- R7: A pin whose direction bit is 1 (output) records no edges. A direction bit of 0 marks the pin as an input.
- R8: A pin change that is applied before clock edge k shows in status and on the interrupt outputs after edge k+2, and not earlier.
- R9: If an armed edge and a clearing write to the same status bit occur in the same cycle, the bit stays 1.
- R10: After synchronous reset, all enables, status bits and direction bits are 0. The interrupt outputs and `reg_rdata` are also 0.
- R11: Values written to the enable and direction registers read back unchanged on `reg_rdata` one cycle after their address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_BANKS*BANK_W | Asynchronous pin levels |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | clog2(NUM_BANKS)+2 | Bank number and register select |
| reg_wdata | input | BANK_W | Write data |
| reg_rdata | output | BANK_W | Registered read data for reg_addr |
| irq_pin0 | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for pin 1 |
| irq_summary | output | 1 | Shared interrupt for pins 2 and up |

## Verification
The hardest case to reach from the ports is the collision between a freshly detected edge and a software clear of the same status bit in the same cycle. Reaching it means timing the write against the two-stage synchronizer plus the compare stage. The bench changes the pin on a falling clock edge and counts exactly two rising edges. It then raises the clearing write so that the write lands on the edge where the new event is recorded. The random phase mixes enable, direction and clear writes with sparse pin toggles. After each step it waits out the pipeline and then compares every status bank against a model built from the requirements.

// File: rtl/gei_pkg.sv
package gei_pkg;
  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DIR  = 2'd3
  } gei_sel_e;
endpackage

// File: rtl/gei_sync.sv
module gei_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/gei_bank.sv
module gei_bank
  import gei_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  gei_sel_e     sel,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise_det,
  input  logic [W-1:0] fall_det,
  output logic [W-1:0] rise_en_q,
  output logic [W-1:0] fall_en_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] stat_next
);
  logic [W-1:0] hit, clr;

  always_comb begin
    hit       = ((rise_det & rise_en_q) | (fall_det & fall_en_q)) & ~dir_q;
    clr       = (wr_en && sel == SEL_STAT) ? wdata : '0;
    stat_next = (stat_q & ~clr) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
      dir_q     <= '0;
      stat_q    <= '0;
    end else begin
      stat_q <= stat_next;
      if (wr_en) begin
        case (sel)
          SEL_RISE: rise_en_q <= wdata;
          SEL_FALL: fall_en_q <= wdata;
          SEL_DIR:  dir_q     <= wdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gei_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 32,
  localparam int NPINS    = NUM_BANKS * BANK_W,
  localparam int BANK_AW  = $clog2(NUM_BANKS),
  localparam int ADDR_W   = BANK_AW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BANK_W-1:0] reg_wdata,
  output logic [BANK_W-1:0] reg_rdata,
  output logic              irq_pin0,
  output logic              irq_pin1,
  output logic              irq_summary
);
  logic [NUM_BANKS-1:0][BANK_W-1:0] rise_det_a, fall_det_a;
  logic [NUM_BANKS-1:0][BANK_W-1:0] rise_en_a, fall_en_a, dir_a;
  logic [NUM_BANKS-1:0][BANK_W-1:0] stat_a, next_a;
  logic [NPINS-1:0]   stat_flat, next_flat;
  logic [BANK_AW-1:0] bank_idx;
  gei_sel_e           sel;
  logic [BANK_W-1:0]  rdata_q;
  logic               summary_q;

  assign bank_idx = reg_addr[ADDR_W-1:2];
  assign sel      = gei_sel_e'(reg_addr[1:0]);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = reg_wr && (bank_idx == BANK_AW'(b));

    gei_sync #(.W(BANK_W)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .pin_in (pin_in[b*BANK_W +: BANK_W]),
      .rise_o (rise_det_a[b]),
      .fall_o (fall_det_a[b])
    );

    gei_bank #(.W(BANK_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (bank_wr),
      .sel       (sel),
      .wdata     (reg_wdata),
      .rise_det  (rise_det_a[b]),
      .fall_det  (fall_det_a[b]),
      .rise_en_q (rise_en_a[b]),
      .fall_en_q (fall_en_a[b]),
      .dir_q     (dir_a[b]),
      .stat_q    (stat_a[b]),
      .stat_next (next_a[b])
    );
  end

  assign stat_flat = stat_a;
  assign next_flat = next_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q   <= '0;
      summary_q <= 1'b0;
    end else begin
      summary_q <= |next_flat[NPINS-1:2];
      case (sel)
        SEL_RISE: rdata_q <= rise_en_a[bank_idx];
        SEL_FALL: rdata_q <= fall_en_a[bank_idx];
        SEL_STAT: rdata_q <= stat_a[bank_idx];
        default:  rdata_q <= dir_a[bank_idx];
      endcase
    end
  end

  assign reg_rdata   = rdata_q;
  assign irq_pin0    = stat_flat[0];
  assign irq_pin1    = stat_flat[1];
  assign irq_summary = summary_q;
endmodule

// File: rtl/gei_checker.sv
module gei_checker #(
  parameter int NPINS  = 128,
  parameter int ADDR_W = 4,
  parameter int BANK_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [BANK_W-1:0] reg_wdata,
  input logic              irq_pin0,
  input logic              irq_summary,
  input logic [NPINS-1:0]  stat_flat,
  input logic              rdet0,
  input logic              fdet0,
  input logic              ren0,
  input logic              fen0,
  input logic              dir0
);
  logic clr0, ev0;
  assign clr0 = reg_wr && (reg_addr == ADDR_W'(2)) && reg_wdata[0];
  assign ev0  = !dir0 && ((rdet0 && ren0) || (fdet0 && fen0));

  p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_pin0 && !clr0) |=> irq_pin0);

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (clr0 && !ev0) |=> !irq_pin0);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ev0 |=> irq_pin0);

  // R1, R6, R7: a new event on pin 0 needs an armed edge on an input pin
  p_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pin0) |-> $past(ev0));

  p_summary_r5: assert property (@(posedge clk) disable iff (rst)
    irq_summary == (|stat_flat[NPINS-1:2]));
endmodule

bind gpio_edge_irq gei_checker #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .irq_pin0    (irq_pin0),
  .irq_summary (irq_summary),
  .stat_flat   (stat_flat),
  .rdet0       (rise_det_a[0][0]),
  .fdet0       (fall_det_a[0][0]),
  .ren0        (rise_en_a[0][0]),
  .fen0        (fall_en_a[0][0]),
  .dir0        (dir_a[0][0])
);

// File: tb/tb_gpio_edge_irq.sv
module tb_gpio_edge_irq;
  localparam int NB = 4;
  localparam int BW = 32;
  localparam int NP = NB * BW;
  localparam int AW = $clog2(NB) + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [BW-1:0] reg_wdata = '0;
  logic [BW-1:0] reg_rdata;
  logic irq_pin0, irq_pin1, irq_summary;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [BW-1:0] m_rise [NB];
  logic [BW-1:0] m_fall [NB];
  logic [BW-1:0] m_dir  [NB];
  logic [BW-1:0] m_stat [NB];

  always #5 clk = ~clk;

  gpio_edge_irq #(.NUM_BANKS(NB), .BANK_W(BW)) dut (
    .clk(clk), .rst(rst), .pin_in(pins), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_summary(irq_summary)
  );

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [AW-1:0] addr_of(input int bank, input int sel);
    return AW'((bank << 2) | sel);
  endfunction

  function automatic logic exp_summary();
    logic s = 1'b0;
    for (int b = 0; b < NB; b++)
      s |= |(b == 0 ? (m_stat[b] & ~32'h3) : m_stat[b]);
    return s;
  endfunction

  task automatic wr_reg(input int bank, input int sel, input logic [BW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr_of(bank, sel); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (sel == 0) m_rise[bank] = d;
    if (sel == 1) m_fall[bank] = d;
    if (sel == 3) m_dir[bank]  = d;
    if (sel == 2) m_stat[bank] &= ~d;
  endtask

  task automatic rd_reg(input int bank, input int sel, output logic [BW-1:0] d);
    @(negedge clk);
    reg_addr = addr_of(bank, sel);
    @(negedge clk);
    d = reg_rdata;
  endtask

  // apply pin vector and update model per R1/R6/R7, then wait out the R8 latency
  task automatic apply_pins(input logic [NP-1:0] nv);
    for (int p = 0; p < NP; p++) begin
      if (nv[p] != pins[p] && !m_dir[p/BW][p%BW]) begin
        if (nv[p] && m_rise[p/BW][p%BW]) m_stat[p/BW][p%BW] = 1'b1;
        if (!nv[p] && m_fall[p/BW][p%BW]) m_stat[p/BW][p%BW] = 1'b1;
      end
    end
    @(negedge clk);
    pins = nv;
    repeat (4) @(negedge clk);
  endtask

  task automatic compare_all(input string tag);
    logic [BW-1:0] d;
    check(irq_pin0 == m_stat[0][0], {tag, " R4 pin0"}, BW'(irq_pin0), BW'(m_stat[0][0]));
    check(irq_pin1 == m_stat[0][1], {tag, " R4 pin1"}, BW'(irq_pin1), BW'(m_stat[0][1]));
    check(irq_summary == exp_summary(), {tag, " R5 summary"}, BW'(irq_summary),
          BW'(exp_summary()));
    for (int b = 0; b < NB; b++) begin
      rd_reg(b, 2, d);
      check(d == m_stat[b], {tag, " R3 status"}, d, m_stat[b]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [BW-1:0] d;
    logic [NP-1:0] nv;
    void'($urandom(32'h5eed1234));
    for (int b = 0; b < NB; b++) begin
      m_rise[b] = '0; m_fall[b] = '0; m_dir[b] = '0; m_stat[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    check(!irq_pin0 && !irq_pin1 && !irq_summary, "R10 outputs", {irq_pin0, irq_pin1, irq_summary}, 0);
    check(reg_rdata == 0, "R10 rdata", reg_rdata, 0);
    for (int b = 0; b < NB; b++)
      for (int s = 0; s < 4; s++) begin
        rd_reg(b, s, d);
        check(d == 0, "R10 register", d, 0);
      end

    // R11: readback
    wr_reg(1, 0, 32'hA5A5_0F0F);
    wr_reg(3, 3, 32'h1234_5678);
    rd_reg(1, 0, d); check(d == 32'hA5A5_0F0F, "R11 rise readback", d, 32'hA5A5_0F0F);
    rd_reg(3, 3, d); check(d == 32'h1234_5678, "R11 dir readback", d, 32'h1234_5678);
    wr_reg(1, 0, 0);
    wr_reg(3, 3, 0);

    // R8 and R1: pin 5 rising only
    wr_reg(0, 0, 32'h20);
    @(negedge clk); pins[5] = 1'b1;
    repeat (2) @(negedge clk);
    check(!irq_summary, "R8 too early", BW'(irq_summary), 0);
    @(negedge clk);
    check(irq_summary, "R8 at edge k+2", BW'(irq_summary), 1);
    m_stat[0][5] = 1'b1;
    wr_reg(0, 2, 32'h20);
    apply_pins(pins & ~(NP'(1) << 5));
    check(!irq_summary, "R1 falling ignored when only rising armed", BW'(irq_summary), 0);

    // R2: pin 70 is bank 2 bit 6, falling edge
    wr_reg(2, 1, 32'h40);
    apply_pins(pins | (NP'(1) << 70));
    rd_reg(2, 2, d); check(d == 0, "R2 rising not armed", d, 0);
    apply_pins(pins & ~(NP'(1) << 70));
    rd_reg(2, 2, d); check(d == 32'h40, "R2 bank2 bit6", d, 32'h40);

    // R3: writing zero leaves the bit, writing back the read value clears it
    wr_reg(2, 2, 32'h0);
    rd_reg(2, 2, d); check(d == 32'h40, "R3 zero write no effect", d, 32'h40);
    wr_reg(2, 2, d);
    rd_reg(2, 2, d); check(d == 0, "R3 write-back clears", d, 0);

    // R1 and R4: pins 0 and 1 on both edges
    wr_reg(0, 0, 32'h3); wr_reg(0, 1, 32'h3);
    apply_pins(pins | NP'(1));
    check(irq_pin0 && !irq_pin1, "R4 pin0 only", {irq_pin0, irq_pin1}, 2'b10);
    apply_pins(pins | NP'(2));
    apply_pins(pins & ~NP'(1));
    compare_all("R1 both edges");
    wr_reg(0, 2, 32'h3);
    check(!irq_pin0 && !irq_pin1, "R3 dedicated clear", {irq_pin0, irq_pin1}, 0);

    // R6: enables off
    wr_reg(0, 0, 0); wr_reg(0, 1, 0);
    apply_pins(pins ^ NP'(3));
    check(!irq_pin0 && !irq_pin1, "R6 disabled pins", {irq_pin0, irq_pin1}, 0);

    // R7: output direction
    wr_reg(3, 0, 32'hFFFF_FFFF); wr_reg(3, 3, 32'h0000_0100);
    apply_pins(pins | (NP'(1) << 104));
    rd_reg(3, 2, d); check(d == 0, "R7 output pin ignored", d, 0);
    wr_reg(3, 3, 0);
    wr_reg(3, 0, 0);

    // R9: edge and clear collide on pin 0, status already set
    wr_reg(0, 0, 32'h1);
    apply_pins(pins & ~NP'(1));
    apply_pins(pins | NP'(1));
    check(irq_pin0, "R9 setup", BW'(irq_pin0), 1);
    wr_reg(0, 1, 32'h1);
    @(negedge clk); pins[0] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = addr_of(0, 2); reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 1'b0;
    check(irq_pin0, "R9 set wins over clear", BW'(irq_pin0), 1);
    repeat (2) @(negedge clk);
    check(irq_pin0, "R9 stays set", BW'(irq_pin0), 1);
    m_stat[0][0] = 1'b1;

    // random phase
    for (int step = 0; step < 300; step++) begin
      for (int w = 0; w < int'($urandom_range(0, 3)); w++) begin
        int s;
        s = $urandom_range(0, 3);
        if (s == 2) wr_reg($urandom_range(0, NB - 1), 2, $urandom() & $urandom());
        else wr_reg($urandom_range(0, NB - 1), s, $urandom() | ((s == 3) ? 0 : $urandom()));
      end
      nv = pins;
      for (int b = 0; b < NB; b++)
        nv[b*BW +: BW] = nv[b*BW +: BW] ^ ($urandom() & $urandom() & $urandom());
      apply_pins(nv);
      if (step % 10 == 9) compare_all("random R1 R7");
    end
    compare_all("final");

    done = 1;
    finish_run();
  end
endmodule